// File: doc/BRIEF.md
# Run-Length Waveform Capture Encoder

The block watches two digital pins of a bus controller, the transmit-enable pin and the data pin, and samples them once per clock tick. At 160 MHz this gives a resolution of 6.25 ns. It does not store every sample. It stores each stretch of constant level as one 16-bit entry that holds the two levels and the length of the stretch. Entries go into an on-chip buffer, which keeps capture in real time with no external memory in the path. Entries use the same layout that a waveform sequence generator consumes, so a captured trace can be read back by a host or replayed as it is.

A host pulses `start_i` to clear the buffer and begin recording. It pulses `stop_i` to end recording, which writes the run in progress as a last entry. After that it reads entries through a synchronous read port. The count output gives the number of valid entries. A sticky flag reports that the buffer ran out of room.

Both pin inputs first pass through a synchroniser. A run ends when either level changes or when its length reaches the largest value the 13-bit duration field can hold. A run whose length is a whole multiple of 16 is stored in scaled form.

Top module: `rlc_capture`

## Requirements
- R1: After reset, `entry_count_o` is 0 and `overflow_o` is 0.
- R2: Each entry uses this layout: bit 15 is the transmit-enable level, bit 14 is the data level, bit 13 is the ×16 flag, and bits 12..0 are the duration. The duration field is never 0.
- R3: Both pins pass through a synchroniser of SYNC_STAGES flops (default 2). The sample present at the start edge opens the first run. Each later tick either extends the run or, if either level differs from the run's level, closes the run and writes one entry whose duration is its length in ticks.
- R4: A run still unbroken at 8191 ticks is written as an unscaled entry of 8191, and a new run of the same level begins on the next tick.
- R5: A run of length L, with L ≥ 16 and L a multiple of 16, is written with bit 13 set and duration L/16. Any other length is written with bit 13 clear and duration L.
- R6: `stop_i` during capture writes the run in progress as a final entry and ends capture. The sample taken in the stop cycle is not counted.
- R7: `start_i` while idle clears the entry count and the overflow flag and begins capture. `start_i` during capture has no effect on the entries.
- R8: `stop_i` while idle changes neither the entry count nor the stored entries.
- R9: The buffer holds DEPTH entries (default 64). An entry that arrives while DEPTH entries are stored is dropped, `overflow_o` becomes 1 and stays 1 until the next start, and capture halts. Exactly DEPTH entries does not set the flag.
- R10: `rd_data_o` presents the entry stored at `rd_addr_i` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| pin_en_i | input | 1 | Asynchronous transmit-enable pin level |
| pin_data_i | input | 1 | Asynchronous data pin level |
| start_i | input | 1 | Pulse: clear buffer and begin capture |
| stop_i | input | 1 | Pulse: flush current run and end capture |
| rd_addr_i | input | $clog2(DEPTH) | Entry index to read |
| rd_data_o | output | 16 | Entry at the index, one cycle later |
| entry_count_o | output | $clog2(DEPTH)+1 | Number of stored entries |
| overflow_o | output | 1 | Sticky: an entry was dropped for lack of space |

## Verification
The first pattern mixes all four level pairs with run lengths of 1, 3, 5, 16, 17, 32 and 48. This separates a change on the enable pin from a change on the data pin, and scaled lengths from lengths that are near misses. A second pattern holds one level for an exact 8191 ticks and for just over twice 8191 ticks, which separates a run that ends by a level change from one that is split by saturation. Dense trains of short runs fill the buffer to exactly its depth and then past it, which separates the full-but-valid case from overflow. Repeated capture of the same pattern, with a stray start pulse during capture and a stray stop pulse while idle, shows that those controls leave the results unchanged.

// File: rtl/rlc_pkg.sv
package rlc_pkg;

    localparam int DUR_W   = 13;
    localparam int LVL_W   = 2;
    localparam int ENTRY_W = LVL_W + 1 + DUR_W;
    localparam int SCALE_SH = 4;

    localparam logic [DUR_W-1:0] DUR_MAX  = {DUR_W{1'b1}};
    localparam logic [DUR_W-1:0] DUR_ONE  = DUR_W'(1);
    localparam logic [DUR_W-1:0] SCALE_MIN = DUR_W'(1 << SCALE_SH);

    // bit 1 = transmit-enable level, bit 0 = data level
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic             en;
        logic             dat;
        logic             x16;
        logic [DUR_W-1:0] dur;
    } entry_t;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_RUN  = 1'b1
    } cap_state_e;

    function automatic logic scalable(input logic [DUR_W-1:0] len);
        return (len >= SCALE_MIN) && (len[SCALE_SH-1:0] == '0);
    endfunction

    function automatic entry_t make_entry(input lvl_t lvl,
                                          input logic [DUR_W-1:0] len,
                                          input logic use_scale);
        entry_t e;
        e.en  = lvl[1];
        e.dat = lvl[0];
        e.x16 = use_scale;
        e.dur = use_scale ? (len >> SCALE_SH) : len;
        return e;
    endfunction

endpackage

// File: rtl/rlc_sync.sv
module rlc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/rlc_run_tracker.sv
module rlc_run_tracker
    import rlc_pkg::*;
#(
    parameter bit SCALE_EN = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  lvl_t   sample,
    input  logic   start,
    input  logic   stop,
    input  logic   halt,
    output logic   running,
    output logic   emit,
    output entry_t entry
);
    cap_state_e       state;
    lvl_t             run_lvl;
    logic [DUR_W-1:0] run_len;
    logic             changed;
    logic             saturated;
    logic             scale_ok;

    assign running   = (state == CAP_RUN);
    assign changed   = (sample != run_lvl);
    assign saturated = (run_len == DUR_MAX);
    assign emit      = running && (stop || changed || saturated);

    if (SCALE_EN) begin : g_scale
        assign scale_ok = scalable(run_len);
    end else begin : g_plain
        assign scale_ok = 1'b0;
    end

    assign entry = make_entry(run_lvl, run_len, scale_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CAP_IDLE;
            run_lvl <= '0;
            run_len <= '0;
        end else begin
            case (state)
                CAP_IDLE: begin
                    if (start) begin
                        state   <= CAP_RUN;
                        run_lvl <= sample;
                        run_len <= DUR_ONE;
                    end
                end
                CAP_RUN: begin
                    if (halt || stop) begin
                        state <= CAP_IDLE;
                    end else if (changed || saturated) begin
                        run_lvl <= sample;
                        run_len <= DUR_ONE;
                    end else begin
                        run_len <= run_len + DUR_ONE;
                    end
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rlc_entry_buf.sv
module rlc_entry_buf
    import rlc_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               wr_req,
    input  entry_t             wr_entry,
    input  logic [AW-1:0]      rd_addr,
    output logic [ENTRY_W-1:0] rd_data,
    output logic [AW:0]        count,
    output logic               overflow,
    output logic               full
);
    localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);
    localparam logic [AW:0] CNT_ONE = (AW+1)'(1);

    logic [ENTRY_W-1:0] mem [DEPTH];
    logic               do_write;

    assign full     = (count == DEPTH_C);
    assign do_write = wr_req && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (clear) begin
            count    <= '0;
            overflow <= 1'b0;
        end else if (do_write) begin
            count <= count + CNT_ONE;
        end else if (wr_req) begin
            overflow <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_write) mem[count[AW-1:0]] <= wr_entry;
    end

    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/rlc_capture.sv
module rlc_capture
    import rlc_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int SYNC_STAGES = 2,
    parameter bit SCALE_EN    = 1'b1,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pin_en_i,
    input  logic               pin_data_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic [AW-1:0]      rd_addr_i,
    output logic [ENTRY_W-1:0] rd_data_o,
    output logic [AW:0]        entry_count_o,
    output logic               overflow_o
);
    lvl_t   pins_sync;
    logic   running;
    logic   emit;
    logic   buf_full;
    logic   halt;
    logic   clear;
    entry_t cur_entry;

    assign halt  = emit && buf_full;
    assign clear = start_i && !running;

    rlc_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({pin_en_i, pin_data_i}),
        .dout (pins_sync)
    );

    rlc_run_tracker #(.SCALE_EN(SCALE_EN)) u_track (
        .clk     (clk),
        .rst     (rst),
        .sample  (pins_sync),
        .start   (start_i),
        .stop    (stop_i),
        .halt    (halt),
        .running (running),
        .emit    (emit),
        .entry   (cur_entry)
    );

    rlc_entry_buf #(.DEPTH(DEPTH)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .wr_req   (emit),
        .wr_entry (cur_entry),
        .rd_addr  (rd_addr_i),
        .rd_data  (rd_data_o),
        .count    (entry_count_o),
        .overflow (overflow_o),
        .full     (buf_full)
    );
endmodule

// File: rtl/rlc_capture_chk.sv
module rlc_capture_chk #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        running,
    input logic        wr_req,
    input logic [15:0] wr_entry,
    input logic [AW:0] entry_count,
    input logic        overflow
);
    localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);
    localparam logic [AW:0] CNT_ONE = (AW+1)'(1);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) entry_count <= DEPTH_C); // R9
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst) (start_i && !running) |=> (entry_count == '0 && !overflow)); // R7
    AST_WRITE_GROWS: assert property (@(posedge clk) disable iff (rst) (wr_req && entry_count < DEPTH_C) |=> (entry_count == $past(entry_count) + CNT_ONE)); // R3
    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst) (wr_req && entry_count == DEPTH_C) |=> (overflow && !running && entry_count == DEPTH_C)); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst) (overflow && !start_i) |=> overflow); // R9
    AST_DUR_NONZERO: assert property (@(posedge clk) disable iff (rst) wr_req |-> (wr_entry[12:0] != '0)); // R2
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst) !running |-> !wr_req); // R8
    AST_X16_RANGE: assert property (@(posedge clk) disable iff (rst) (wr_req && wr_entry[13]) |-> (wr_entry[12:0] <= 13'd511)); // R5
endmodule

bind rlc_capture rlc_capture_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .running     (running),
    .wr_req      (emit),
    .wr_entry    (cur_entry),
    .entry_count (entry_count_o),
    .overflow    (overflow_o)
);

// File: tb/rlc_capture_tb.sv
module rlc_capture_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int AW         = $clog2(DEPTH);
    localparam int SYNC       = 2;
    localparam int MAXLEN     = 8191;
    localparam int WD_CYCLES  = 150000;

    typedef struct {
        logic [1:0] lvl;
        int         len;
    } seg_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pin_en = 1'b0;
    logic          pin_data = 1'b0;
    logic          start = 1'b0;
    logic          stop = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic [AW:0]   entry_count;
    logic          overflow;

    int            checks = 0;
    int            fails = 0;
    seg_t          segs[$];
    logic [15:0]   exp_q[$];
    int            exp_cnt;
    bit            exp_ovf;

    always #(CLK_PERIOD/2) clk = ~clk;

    rlc_capture #(.DEPTH(DEPTH)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .pin_en_i      (pin_en),
        .pin_data_i    (pin_data),
        .start_i       (start),
        .stop_i        (stop),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data),
        .entry_count_o (entry_count),
        .overflow_o    (overflow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] encode(input logic [1:0] lvl, input int len);
        if (len >= 16 && (len % 16) == 0)
            return {lvl, 1'b1, 13'(len / 16)};
        return {lvl, 1'b0, 13'(len)};
    endfunction

    // driver: plays segs and pushes the expected entries into the scoreboard queue
    task automatic play(input int extra_start_at);
        logic [1:0] drv[$];
        logic [1:0] v0;
        logic [1:0] s;
        logic [1:0] cur;
        int         len;
        int         total;
        bit         halted;
        v0 = segs[0].lvl;
        foreach (segs[k]) for (int j = 0; j < segs[k].len; j++) drv.push_back(segs[k].lvl);
        total = drv.size() + SYNC;
        exp_cnt = 0; exp_ovf = 0; halted = 0; cur = v0; len = 0;
        for (int t = 0; t < total; t++) begin
            s = (t < SYNC) ? v0 : drv[t-SYNC];
            if (t == 0) begin cur = s; len = 1; continue; end
            if (s != cur || len == MAXLEN) begin
                if (exp_cnt == DEPTH) begin exp_ovf = 1; halted = 1; break; end
                exp_q.push_back(encode(cur, len)); exp_cnt++;
                cur = s; len = 1;
            end else len++;
        end
        if (!halted) begin
            if (exp_cnt == DEPTH) exp_ovf = 1;
            else begin exp_q.push_back(encode(cur, len)); exp_cnt++; end
        end
        @(negedge clk);
        {pin_en, pin_data} = v0;
        repeat (4) @(negedge clk);
        for (int t = 0; t < total; t++) begin
            if (t > 0) @(negedge clk);
            {pin_en, pin_data} = (t < drv.size()) ? drv[t] : drv[drv.size()-1];
            start = (t == 0) || (t == extra_start_at);
        end
        @(negedge clk);
        start = 1'b0;
        stop  = 1'b1;
        @(negedge clk);
        stop  = 1'b0;
        segs.delete();
    endtask

    // monitor: reads the buffer back and pops the scoreboard
    task automatic drain(input string tag);
        logic [15:0] exp;
        check({tag, " count R9"}, 32'(entry_count), 32'(exp_cnt));
        check({tag, " overflow R9"}, 32'(overflow), 32'(exp_ovf));
        for (int i = 0; i < exp_cnt; i++) begin
            @(negedge clk);
            rd_addr = AW'(i);
            @(negedge clk);
            exp = exp_q.pop_front();
            check($sformatf("%s entry %0d R2 R10", tag, i), 32'(rd_data), 32'(exp));
        end
        exp_q.delete();
    endtask

    task automatic add(input logic [1:0] lvl, input int len);
        seg_t s;
        s.lvl = lvl; s.len = len;
        segs.push_back(s);
    endtask

    task automatic mixed_pattern();
        add(2'b00, 5); add(2'b01, 16); add(2'b11, 17); add(2'b10, 32);
        add(2'b00, 1); add(2'b01, 48); add(2'b11, 3);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R1 actual=%0d cycles expected=fewer", WD_CYCLES);
        finish_run();
    end

    initial begin
        logic [AW:0] cnt_before;
        logic [15:0] e0_before;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("reset count R1", 32'(entry_count), 32'd0);
        check("reset overflow R1", 32'(overflow), 32'd0);

        // R3 R5 R6: mixed levels and lengths, flushed at stop
        mixed_pattern();
        play(-1);
        drain("mixed R3 R5 R6");

        // R4: exact-limit run and a run split twice by saturation
        add(2'b01, 4); add(2'b00, MAXLEN); add(2'b10, 2*MAXLEN + 3); add(2'b01, 2);
        play(-1);
        drain("saturate R4");

        // R7: stray start during capture changes nothing
        mixed_pattern();
        play(20);
        drain("stray start R7");

        // R8: stop while idle
        cnt_before = entry_count;
        @(negedge clk); rd_addr = '0;
        @(negedge clk); e0_before = rd_data;
        stop = 1'b1;
        @(negedge clk); stop = 1'b0;
        @(negedge clk);
        check("idle stop count R8", 32'(entry_count), 32'(cnt_before));
        @(negedge clk);
        check("idle stop entry R8", 32'(rd_data), 32'(e0_before));

        // R9: exactly DEPTH entries, no overflow
        for (int i = 0; i < DEPTH; i++) add(2'(i % 4), 2 + (i % 3));
        play(-1);
        drain("full R9");

        // R9: past DEPTH entries, overflow and halt
        for (int i = 0; i < DEPTH + 6; i++) add((i % 2) ? 2'b10 : 2'b01, 3);
        play(-1);
        drain("overflow R9");

        // R7: a new start clears the overflow flag
        mixed_pattern();
        play(-1);
        drain("restart R7");

        finish_run();
    end
endmodule